// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits between a set of numbered interrupt request lines, one non-maskable request, and a CPU that takes a single interrupt input. Line 0 has the most priority and each higher line number has less. The non-maskable request outranks every line. The block raises one combined request toward the CPU. When the CPU acknowledges, the block announces the winner's line number in binary on a one-cycle strobe. Each device compares that number with its own. The winning device then places its 8-bit vector on a shared bus, and the block hands that vector to the CPU as an index into its handler table.

The block keeps a record of the level now in service. A new request reaches the CPU only when its priority is strictly above that level. The record is a small stack, so preemptions can nest. Each return pulse from the CPU removes the newest entry and restores the level that was in service before it. Any request still pending is then presented again without the device having to raise it a second time.

Top module: `pvic_top`

## Requirements
- R1: With no level in service, `intReq` is high in the same cycle as any line of `irqLine` is high. In general, `intReq` is high exactly when some line has a strictly lower number than the level in service, or a non-maskable request is pending and eligible (see R9).
- R2: When several eligible lines are high at once, the lowest-numbered one wins. `ackLvl` carries its number in binary and `ackNmi` is 0.
- R3: An `intAck` is accepted only if `intReq` is high, `ackStb` is low and `retPulse` is low in that cycle. An accepted `intAck` makes `ackStb` high for exactly the next cycle. An `intAck` that is not accepted has no effect.
- R4: `devVec` is sampled in the cycle that `ackStb` is high. In the following cycle, that value appears on `vecOut` and `vecValid` is high, for one cycle.
- R5: While a level is in service, lines of the same or a lower priority (equal or higher number) do not raise `intReq`.
- R6: A strictly higher request raises `intReq` during service and can be acknowledged. That nests a new level. Each `retPulse` restores the level that was in service before the newest one. The stack holds up to NUM_LVL+1 levels.
- R7: A `retPulse` with no level in service is ignored. The level stays "none".
- R8: After a return, a line that stayed high the whole time raises `intReq` again without dropping and re-rising, provided it is now eligible.
- R9: A rising edge of `nmiReq` sets a pending flag, which is cleared when that request is acknowledged. A pending non-maskable request is never masked by a numbered level in service. It wins over every line and is reported with `ackNmi`=1 and `ackLvl`=0. A new edge that arrives while a non-maskable handler is in service stays pending until a return.
- R10: After reset, `intReq`, `ackStb` and `vecValid` are low and no level is in service.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| irqLine | input | NUM_LVL | Level request lines; bit i is line i, and line 0 has the most priority |
| nmiReq | input | 1 | Non-maskable request, rising-edge detected |
| intAck | input | 1 | CPU acknowledge of `intReq` |
| retPulse | input | 1 | CPU return-from-interrupt pulse |
| devVec | input | VEC_W | Vector driven by the acknowledged device |
| intReq | output | 1 | Combined request to the CPU |
| ackStb | output | 1 | One-cycle strobe announcing the winner |
| ackLvl | output | LVL_W | Winning line number in binary |
| ackNmi | output | 1 | The winner is the non-maskable request |
| vecOut | output | VEC_W | Vector forwarded to the CPU |
| vecValid | output | 1 | `vecOut` is valid this cycle |

## Verification
The situations that are hardest to reach from the ports are deep unwinding of the level stack and a second non-maskable edge that arrives while a non-maskable handler is already in service. To reach them, the stimulus first acknowledges a numbered line. It then stacks a non-maskable acknowledge on top of that line. Next it toggles `nmiReq` during that service, and checks that the new edge stays hidden until the return and is then served on top of the restored line level. Other sequences check that the restored level is the right one. They raise a line that sits between two nested levels, or one below both, right after a return. They also send an `intAck` in the strobe cycle, where a higher line has just appeared, and check that it is discarded.

// File: rtl/pvic_pkg.sv
package pvic_pkg;
  // strobes passed from control to datapath
  typedef struct packed {
    logic push;    // store a newly acknowledged level
    logic pop;     // return from the newest level
    logic nmiWin;  // the acknowledged winner is the non-maskable request
  } pvicStrb_t;
endpackage

// File: rtl/pvic_ctrl.sv
module pvic_ctrl
  import pvic_pkg::*;
#(
  parameter int NUM_LVL = 8,
  localparam int RANK_W = $clog2(NUM_LVL + 2)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_LVL-1:0] irqLine,
  input  logic              nmiReq,
  input  logic              intAck,
  input  logic              retPulse,
  input  logic [RANK_W-1:0] curRank,
  input  logic              ackBusy,
  output logic              intReq,
  output pvicStrb_t         strb,
  output logic [RANK_W-1:0] pushRank
);
  // rank 0 = non-maskable, rank i+1 = line i, rank NUM_LVL+1 = none
  localparam logic [RANK_W-1:0] IDLE_RANK = RANK_W'(NUM_LVL + 1);

  logic nmiLast, nmiPend, nmiElig;
  logic [NUM_LVL-1:0] lineElig;
  logic [RANK_W-1:0] winRank;
  logic accept;

  // non-maskable edge capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nmiLast <= 1'b0;
      nmiPend <= 1'b0;
    end else begin
      nmiLast <= nmiReq;
      if (nmiReq && !nmiLast) nmiPend <= 1'b1;
      else if (strb.nmiWin)   nmiPend <= 1'b0;
    end
  end

  // per-line qualification against the level in service
  for (genvar i = 0; i < NUM_LVL; i++) begin : gElig
    localparam logic [RANK_W-1:0] LINE_RANK = RANK_W'(i + 1);
    assign lineElig[i] = irqLine[i] && (LINE_RANK < curRank);
  end

  assign nmiElig = nmiPend && (curRank != '0);

  // lowest rank wins
  always_comb begin
    winRank = IDLE_RANK;
    for (int i = NUM_LVL - 1; i >= 0; i--) begin
      if (lineElig[i]) winRank = RANK_W'(i + 1);
    end
    if (nmiElig) winRank = '0;
  end

  assign intReq   = nmiElig || (|lineElig);
  assign accept   = intAck && intReq && !ackBusy && !retPulse;
  assign pushRank = winRank;

  always_comb begin
    strb.push   = accept;
    strb.pop    = retPulse;
    strb.nmiWin = accept && (winRank == '0);
  end

  AST_PUSH_HIGHER: assert property (@(posedge clk) disable iff (!rstN)
    strb.push |-> (pushRank < curRank)); // R5
  AST_IDLE_REQ: assert property (@(posedge clk) disable iff (!rstN)
    ((|irqLine) && curRank == IDLE_RANK) |-> intReq); // R1
  AST_NMI_UNMASKED: assert property (@(posedge clk) disable iff (!rstN)
    (nmiPend && curRank != '0) |-> intReq); // R9
  AST_NO_ACK_IN_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    ackBusy |-> !strb.push); // R3
endmodule

// File: rtl/pvic_dp.sv
module pvic_dp
  import pvic_pkg::*;
#(
  parameter int NUM_LVL = 8,
  parameter int VEC_W = 8,
  localparam int RANK_W = $clog2(NUM_LVL + 2),
  localparam int LVL_W = (NUM_LVL > 1) ? $clog2(NUM_LVL) : 1,
  localparam int DEPTH = NUM_LVL + 1,
  localparam int PTR_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  pvicStrb_t         strb,
  input  logic [RANK_W-1:0] pushRank,
  input  logic [VEC_W-1:0]  devVec,
  output logic [RANK_W-1:0] curRank,
  output logic              ackStb,
  output logic [LVL_W-1:0]  ackLvl,
  output logic              ackNmi,
  output logic [VEC_W-1:0]  vecOut,
  output logic              vecValid
);
  localparam logic [RANK_W-1:0] IDLE_RANK = RANK_W'(NUM_LVL + 1);
  localparam logic [PTR_W-1:0]  FULL_PTR  = PTR_W'(DEPTH);

  logic [RANK_W-1:0] stk [DEPTH];
  logic [PTR_W-1:0]  ptr;

  // in-service level stack
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr <= '0;
      for (int k = 0; k < DEPTH; k++) stk[k] <= IDLE_RANK;
    end else if (strb.push && ptr != FULL_PTR) begin
      stk[ptr] <= pushRank;
      ptr <= ptr + 1'b1;
    end else if (strb.pop && ptr != '0) begin
      ptr <= ptr - 1'b1;
    end
  end

  assign curRank = (ptr == '0) ? IDLE_RANK : stk[ptr - 1'b1];

  // acknowledge strobe and vector capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ackStb   <= 1'b0;
      ackLvl   <= '0;
      ackNmi   <= 1'b0;
      vecOut   <= '0;
      vecValid <= 1'b0;
    end else begin
      ackStb   <= strb.push;
      vecValid <= ackStb;
      if (strb.push) begin
        ackNmi <= strb.nmiWin;
        ackLvl <= strb.nmiWin ? '0 : LVL_W'(pushRank - 1'b1);
      end
      if (ackStb) vecOut <= devVec;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    strb.push |-> (ptr < FULL_PTR)); // R6
  AST_EMPTY_RET: assert property (@(posedge clk) disable iff (!rstN)
    (strb.pop && !strb.push && ptr == '0) |=> (ptr == '0)); // R7
  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    ackStb |=> !ackStb); // R3
  AST_VEC_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    ackStb |=> vecValid); // R4
endmodule

// File: rtl/pvic_top.sv
module pvic_top
  import pvic_pkg::*;
#(
  parameter int NUM_LVL = 8,
  parameter int VEC_W = 8,
  localparam int RANK_W = $clog2(NUM_LVL + 2),
  localparam int LVL_W = (NUM_LVL > 1) ? $clog2(NUM_LVL) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_LVL-1:0] irqLine,
  input  logic               nmiReq,
  input  logic               intAck,
  input  logic               retPulse,
  input  logic [VEC_W-1:0]   devVec,
  output logic               intReq,
  output logic               ackStb,
  output logic [LVL_W-1:0]   ackLvl,
  output logic               ackNmi,
  output logic [VEC_W-1:0]   vecOut,
  output logic               vecValid
);
  pvicStrb_t         strb;
  logic [RANK_W-1:0] curRank, pushRank;

  pvic_ctrl #(.NUM_LVL(NUM_LVL)) uCtrl (
    .clk(clk), .rstN(rstN), .irqLine(irqLine), .nmiReq(nmiReq),
    .intAck(intAck), .retPulse(retPulse), .curRank(curRank),
    .ackBusy(ackStb), .intReq(intReq), .strb(strb), .pushRank(pushRank)
  );

  pvic_dp #(.NUM_LVL(NUM_LVL), .VEC_W(VEC_W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .pushRank(pushRank),
    .devVec(devVec), .curRank(curRank), .ackStb(ackStb), .ackLvl(ackLvl),
    .ackNmi(ackNmi), .vecOut(vecOut), .vecValid(vecValid)
  );
endmodule

// File: tb/tb_pvic_top.sv
module tb_pvic_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] irqLine = '0;
  logic nmiReq = 1'b0, intAck = 1'b0, retPulse = 1'b0;
  logic [7:0] devVec = '0;
  logic intReq, ackStb, ackNmi, vecValid;
  logic [2:0] ackLvl;
  logic [7:0] vecOut;
  int checks = 0, failures = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  pvic_top dut (
    .clk(clk), .rstN(rstN), .irqLine(irqLine), .nmiReq(nmiReq),
    .intAck(intAck), .retPulse(retPulse), .devVec(devVec),
    .intReq(intReq), .ackStb(ackStb), .ackLvl(ackLvl), .ackNmi(ackNmi),
    .vecOut(vecOut), .vecValid(vecValid)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic setLines(input logic [7:0] v);
    @(negedge clk); irqLine = v; #1;
  endtask

  task automatic waitCyc();
    @(negedge clk); #1;
  endtask

  task automatic doRet();
    @(negedge clk); retPulse = 1'b1;
    @(negedge clk); retPulse = 1'b0; #1;
  endtask

  task automatic doAck(input bit expNmi, input int expLvl, input logic [7:0] v, input string req);
    @(negedge clk); intAck = 1'b1; devVec = v;
    @(negedge clk); intAck = 1'b0; #1;
    chk(req, "ackStb", ackStb, 1);
    chk(req, "ackNmi", ackNmi, expNmi);
    chk(req, "ackLvl", ackLvl, expLvl);
    @(negedge clk); #1;
    chk("R4", "vecValid", vecValid, 1);
    chk("R4", "vecOut", vecOut, v);
    chk("R3", "ackStb single", ackStb, 0);
    waitCyc();
    chk("R4", "vecValid single", vecValid, 0);
  endtask

  task automatic tReset();
    chk("R10", "intReq", intReq, 0);
    chk("R10", "ackStb", ackStb, 0);
    chk("R10", "vecValid", vecValid, 0);
    setLines(8'h80);
    chk("R1", "idle any line", intReq, 1);
    setLines(8'h00);
    chk("R1", "no lines", intReq, 0);
  endtask

  task automatic tPriority();
    setLines(8'h64);
    chk("R1", "lines 2 5 6", intReq, 1);
    doAck(0, 2, 8'h2A, "R2");
    chk("R5", "equal and lower masked", intReq, 0);
    setLines(8'h60);
    chk("R5", "lower still masked", intReq, 0);
    doRet();
    chk("R8", "pending re-presented", intReq, 1);
    doAck(0, 5, 8'h55, "R2");
    setLines(8'h40);
    doRet();
    chk("R8", "line 6 re-presented", intReq, 1);
    doAck(0, 6, 8'hC3, "R2");
    setLines(8'h00);
    doRet();
    chk("R6", "empty after unwinding", intReq, 0);
  endtask

  task automatic tNested();
    setLines(8'h10);
    doAck(0, 4, 8'h04, "R2");
    setLines(8'h12);
    chk("R6", "preempt by line 1", intReq, 1);
    doAck(0, 1, 8'h11, "R6");
    setLines(8'h1A);
    chk("R5", "line 3 masked by 1", intReq, 0);
    setLines(8'h18);
    doRet();
    chk("R6", "restored level 4 lets 3", intReq, 1);
    setLines(8'h50);
    chk("R6", "restored level 4 masks 6", intReq, 0);
    doRet();
    chk("R6", "back to none", intReq, 1);
    setLines(8'h00);
  endtask

  task automatic tIgnore();
    @(negedge clk); intAck = 1'b1;
    @(negedge clk); intAck = 1'b0; #1;
    chk("R3", "ack without request", ackStb, 0);
    doRet();
    doRet();
    setLines(8'h08);
    doAck(0, 3, 8'h33, "R2");
    setLines(8'h09);
    chk("R7", "level 3 held after empty returns", intReq, 1);
    setLines(8'h08);
    doRet();
    chk("R7", "one return empties", intReq, 1);
    @(negedge clk); intAck = 1'b1; retPulse = 1'b1;
    @(negedge clk); intAck = 1'b0; retPulse = 1'b0; #1;
    chk("R3", "ack with return ignored", ackStb, 0);
    @(negedge clk); intAck = 1'b1; devVec = 8'h3C;
    @(negedge clk); irqLine = 8'h0A; #1;
    chk("R3", "first ack strobe", ackStb, 1);
    chk("R2", "first ack level", ackLvl, 3);
    @(negedge clk); intAck = 1'b0; #1;
    chk("R3", "ack during strobe ignored", ackStb, 0);
    chk("R4", "vector of first ack", vecOut, 8'h3C);
    chk("R6", "line 1 pending over 3", intReq, 1);
    doAck(0, 1, 8'h1F, "R6");
    setLines(8'h00);
    doRet();
    doRet();
    chk("R7", "idle again", intReq, 0);
  endtask

  task automatic tNmi();
    setLines(8'h01);
    doAck(0, 0, 8'h01, "R2");
    @(negedge clk); nmiReq = 1'b1;
    waitCyc();
    chk("R9", "nmi over level 0", intReq, 1);
    doAck(1, 0, 8'hFE, "R9");
    setLines(8'h00);
    chk("R9", "held high no new edge", intReq, 0);
    @(negedge clk); nmiReq = 1'b0;
    @(negedge clk); nmiReq = 1'b1;
    waitCyc();
    chk("R9", "new edge held during nmi", intReq, 0);
    doRet();
    chk("R9", "held edge after return", intReq, 1);
    doAck(1, 0, 8'hEE, "R9");
    doRet();
    doRet();
    chk("R9", "idle after nmi", intReq, 0);
    @(negedge clk); nmiReq = 1'b0;
    @(negedge clk); nmiReq = 1'b1; irqLine = 8'h01;
    waitCyc();
    doAck(1, 0, 8'hAB, "R9");
    chk("R5", "line 0 masked by nmi", intReq, 0);
    doRet();
    chk("R8", "line 0 after nmi", intReq, 1);
    doAck(0, 0, 8'h0B, "R8");
    setLines(8'h00);
    doRet();
    nmiReq = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    tReset();
    tPriority();
    tNested();
    tIgnore();
    tNmi();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule